// File: doc/BRIEF.md
# Section Overhead Descrambler and Extractor

This block sits in the receive path of a SONET/SDH line interface. It works at the byte clock on a byte-aligned stream. A frame pulse marks the first framing byte of each frame. The block tracks the row and column of every byte for STS-1 or STS-3 framing. It optionally removes the frame-synchronous scrambling and forwards the whole stream one byte per beat. On request it replaces everything outside the section overhead with all-ones line AIS.

From the descrambled section overhead it takes the order-wire byte, the user-channel byte and the three data-communication-channel bytes. It shifts them out as slow bit-serial streams, MSB first. Each stream has its own clock pin that pulses high for one cycle with every new bit. The receiver samples the bit while that pulse is high. Framing, loss-of-frame detection and parity checking happen upstream. This block only consumes the loss-of-frame and loss-of-signal levels.

Both stream edges use valid/ready handshakes. A byte transfers on a clock edge where valid and ready are both high. The block holds one byte in its output register. `in_ready` is high while that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output byte and its frame marker stay frozen, and no input byte is taken. All positional state, the keystream and the serial outputs advance only on accepted input beats.

Top module: `soh_extract`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sof` hold their values.
- R2: A byte accepted at a clock edge appears on `out_data` right after that edge, with `out_valid` high. `out_sof` repeats the `in_sof` that came with it.
- R3: A byte accepted with `in_sof` high is row 0, column 0. A row holds 90·N bytes and a frame holds 9 rows, with N=1 when `sts3_mode`=0 and N=3 when it is 1. Positions then step on their own, so a frame pulse that arrives early realigns them.
- R4: With `descr_en`=1, each byte is XORed with a keystream from the generator 1 + x^6 + x^7, taken MSB first. The generator is seeded with all ones for the byte at row 0, column 3N, so that byte gets keystream 0xFE. The keystream advances one byte per accepted byte. The bytes at row 0, columns 0 to 3N−1, are never altered. With `descr_en`=0, bytes pass unchanged.
- R5: While `ais_force`=1, every byte outside the section overhead leaves as 0xFF. The section overhead is rows 0 to 2, columns 0 to 3N−1. Section overhead bytes keep their descrambled value.
- R6: AIS is also applied when `ais_auto_en`=1 and `lof` or `los` is high. With `ais_auto_en`=0, `lof` and `los` have no effect on the output.
- R7: The descrambled byte at row 1, column N is captured. On each following accepted beat it emits one bit on `ow_bit`, MSB first, eight bits in total, and each bit comes with a one-cycle high on `ow_clk`.
- R8: The byte at row 1, column 2N is shifted out on `uc_bit` and `uc_clk` in the same way.
- R9: The bytes at row 2, columns 0, N and 2N are shifted out as one 24-bit burst on `dcc_bit` and `dcc_clk`. The column-0 byte goes first, MSB first, and the burst starts on the beat after the column-2N byte.
- R10: Before the first frame pulse after reset, bytes pass unchanged and no serial clock pulses. AIS, when active, replaces every byte.
- R11: After reset, `out_valid` and all serial clocks are low. A serial clock pulses only in the cycle after an accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first framing byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Descrambled byte, or AIS ones |
| out_sof | output | 1 | Output byte is the first framing byte |
| sts3_mode | input | 1 | 0: STS-1, 1: STS-3 |
| descr_en | input | 1 | Enable descrambling |
| ais_force | input | 1 | Force line AIS |
| ais_auto_en | input | 1 | Allow AIS from lof/los |
| lof | input | 1 | Loss-of-frame status |
| los | input | 1 | Loss-of-signal status |
| dcc_bit | output | 1 | Data communication channel serial data |
| dcc_clk | output | 1 | Data communication channel bit pulse |
| ow_bit | output | 1 | Order-wire serial data |
| ow_clk | output | 1 | Order-wire bit pulse |
| uc_bit | output | 1 | User-channel serial data |
| uc_clk | output | 1 | User-channel bit pulse |

## Verification
The bench checks every byte of whole frames in both rates against a model of its own. This exposes a keystream seeded one byte early or late, and a generator that also runs over the framing bytes; either fault corrupts nearly every payload byte. Each scenario starts with a frame pulse while the block sits mid-frame. A tracker that ignores realignment therefore misplaces the overhead taps, and the serial bit sequences and their pulse counts go wrong. AIS is driven through force, through automatic loss-of-frame and loss-of-signal, and with automatic mode off. A block that blanks the section overhead or ignores the enable shows the wrong bytes. Stalls check that a held byte does not change and that no byte is taken twice, and the pre-sync bytes must pass unchanged.

// File: rtl/soh_extract_pkg.sv
package soh_extract_pkg;
  localparam int BYTE_W    = 8;
  localparam int ROWS      = 9;
  localparam int COLS_STS1 = 90;
  localparam int OH_COLS   = 3;
  localparam int MAX_N     = 3;
  localparam int COL_W     = $clog2(COLS_STS1 * MAX_N);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int LFSR_W    = 7;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } pos_t;

  // keystream byte produced from a generator state, first bit in the MSB
  function automatic logic [BYTE_W-1:0] ks_byte(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] st;
    logic [BYTE_W-1:0] k;
    st = s;
    for (int i = 0; i < BYTE_W; i++) begin
      k[BYTE_W-1-i] = st[LFSR_W-1];
      st = {st[LFSR_W-2:0], st[LFSR_W-1] ^ st[LFSR_W-2]};
    end
    return k;
  endfunction

  // generator state after one byte of output
  function automatic logic [LFSR_W-1:0] ks_next(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] st;
    st = s;
    for (int i = 0; i < BYTE_W; i++)
      st = {st[LFSR_W-2:0], st[LFSR_W-1] ^ st[LFSR_W-2]};
    return st;
  endfunction
endpackage

// File: rtl/soh_pos_tracker.sv
module soh_pos_tracker
  import soh_extract_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic sof,
  input  logic sts3,
  output logic synced,
  output pos_t pos
);
  localparam logic [COL_W-1:0] LEN1 = COL_W'(COLS_STS1);
  localparam logic [COL_W-1:0] LEN3 = COL_W'(COLS_STS1 * MAX_N);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             synced_q;
  pos_t             pos_q;
  logic [COL_W-1:0] row_len;

  assign row_len = sts3 ? LEN3 : LEN1;
  assign synced  = synced_q | sof;
  assign pos     = sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      pos_q    <= '0;
    end else if (advance) begin
      synced_q <= synced;
      if (pos.col >= row_len - COL_W'(1)) begin
        pos_q.col <= '0;
        pos_q.row <= (pos.row == LAST_ROW) ? '0 : pos.row + ROW_W'(1);
      end else begin
        pos_q.col <= pos.col + COL_W'(1);
        pos_q.row <= pos.row;
      end
    end
  end
endmodule

// File: rtl/soh_keystream.sv
module soh_keystream
  import soh_extract_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              reseed,
  output logic [BYTE_W-1:0] key
);
  localparam logic [LFSR_W-1:0] SEED = '1;
  logic [LFSR_W-1:0] state;

  assign key = ks_byte(state);

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= SEED;
    else if (advance) state <= reseed ? SEED : ks_next(state);
  end
endmodule

// File: rtl/soh_serializer.sv
module soh_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         advance,
  output logic         ser_bit,
  output logic         ser_clk
);
  localparam int CW = $clog2(W + 1);
  logic [W-1:0]  sh;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      left    <= '0;
      ser_bit <= 1'b0;
      ser_clk <= 1'b0;
    end else begin
      ser_clk <= 1'b0;
      if (load) begin
        sh   <= load_data;
        left <= CW'(W);
      end else if (advance && left != '0) begin
        ser_bit <= sh[W-1];
        sh      <= sh << 1;
        left    <= left - CW'(1);
        ser_clk <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/soh_extract.sv
module soh_extract
  import soh_extract_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  input  logic              sts3_mode,
  input  logic              descr_en,
  input  logic              ais_force,
  input  logic              ais_auto_en,
  input  logic              lof,
  input  logic              los,
  output logic              dcc_bit,
  output logic              dcc_clk,
  output logic              ow_bit,
  output logic              ow_clk,
  output logic              uc_bit,
  output logic              uc_clk
);
  localparam int DCC_BYTES = 3;
  localparam int DCC_W     = DCC_BYTES * BYTE_W;
  localparam logic [ROW_W-1:0] SOH_LAST_ROW = ROW_W'(2);

  logic              accept, synced, ais_on;
  logic              fixed_zone, is_soh;
  logic              hit_ow, hit_uc, hit_d1, hit_d2, hit_d3;
  pos_t              pos;
  logic [COL_W-1:0]  n_sts, oh_w;
  logic [BYTE_W-1:0] key, descr;
  logic [DCC_W-BYTE_W-1:0] dcc_hold;

  assign accept   = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  soh_pos_tracker u_pos (
    .clk(clk), .rst_n(rst_n), .advance(accept), .sof(in_sof),
    .sts3(sts3_mode), .synced(synced), .pos(pos)
  );

  assign n_sts = sts3_mode ? COL_W'(MAX_N) : COL_W'(1);
  assign oh_w  = sts3_mode ? COL_W'(OH_COLS * MAX_N) : COL_W'(OH_COLS);

  assign fixed_zone = synced && pos.row == '0 && pos.col < oh_w;
  assign is_soh     = synced && pos.row <= SOH_LAST_ROW && pos.col < oh_w;
  assign hit_ow     = synced && pos.row == ROW_W'(1) && pos.col == n_sts;
  assign hit_uc     = synced && pos.row == ROW_W'(1) && pos.col == (n_sts << 1);
  assign hit_d1     = synced && pos.row == ROW_W'(2) && pos.col == '0;
  assign hit_d2     = synced && pos.row == ROW_W'(2) && pos.col == n_sts;
  assign hit_d3     = synced && pos.row == ROW_W'(2) && pos.col == (n_sts << 1);

  soh_keystream u_ks (
    .clk(clk), .rst_n(rst_n), .advance(accept), .reseed(fixed_zone), .key(key)
  );

  assign descr  = in_data ^ ((descr_en && synced && !fixed_zone) ? key : '0);
  assign ais_on = ais_force || (ais_auto_en && (lof || los));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      dcc_hold  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= (ais_on && !is_soh) ? '1 : descr;
        out_sof   <= in_sof;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && hit_d1) dcc_hold[DCC_W-BYTE_W-1 -: BYTE_W] <= descr;
      if (accept && hit_d2) dcc_hold[BYTE_W-1:0] <= descr;
    end
  end

  soh_serializer #(.W(BYTE_W)) u_ow (
    .clk(clk), .rst_n(rst_n), .load(accept && hit_ow), .load_data(descr),
    .advance(accept), .ser_bit(ow_bit), .ser_clk(ow_clk)
  );

  soh_serializer #(.W(BYTE_W)) u_uc (
    .clk(clk), .rst_n(rst_n), .load(accept && hit_uc), .load_data(descr),
    .advance(accept), .ser_bit(uc_bit), .ser_clk(uc_clk)
  );

  soh_serializer #(.W(DCC_W)) u_dcc (
    .clk(clk), .rst_n(rst_n), .load(accept && hit_d3),
    .load_data({dcc_hold, descr}), .advance(accept),
    .ser_bit(dcc_bit), .ser_clk(dcc_clk)
  );
endmodule

// File: rtl/soh_extract_chk.sv
module soh_extract_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       ais_force,
  input logic       is_soh,
  input logic       dcc_clk,
  input logic       ow_clk,
  input logic       uc_clk
);
  a_r1_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));

  a_r5_forced_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid && in_ready && ais_force && !is_soh))
      |-> (out_valid && out_data == 8'hFF));

  a_r11_ow_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ow_clk |-> $past(in_valid && in_ready));

  a_r11_uc_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    uc_clk |-> $past(in_valid && in_ready));

  a_r11_dcc_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    dcc_clk |-> $past(in_valid && in_ready));
endmodule

bind soh_extract soh_extract_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .ais_force(ais_force), .is_soh(is_soh),
  .dcc_clk(dcc_clk), .ow_clk(ow_clk), .uc_clk(uc_clk)
);

// File: tb/sim_soh_extract.sv
module sim_soh_extract;
  localparam int CLK_PERIOD = 10;
  localparam int NSCN = 6;
  // {sts3, descr_en, ais_force, ais_auto_en, lof, los, expected_ais}
  localparam logic [6:0] SCN [NSCN] = '{
    7'b0100000, 7'b0001101, 7'b1100010,
    7'b1110001, 7'b0101011, 7'b1000110
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic sts3_mode = 1'b0, descr_en = 1'b0, ais_force = 1'b0;
  logic ais_auto_en = 1'b0, lof = 1'b0, los = 1'b0;
  logic in_ready, out_valid, out_sof;
  logic [7:0] out_data;
  logic dcc_bit, dcc_clk, ow_bit, ow_clk, uc_bit, uc_clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  soh_extract u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .sts3_mode(sts3_mode), .descr_en(descr_en), .ais_force(ais_force),
    .ais_auto_en(ais_auto_en), .lof(lof), .los(los),
    .dcc_bit(dcc_bit), .dcc_clk(dcc_clk), .ow_bit(ow_bit), .ow_clk(ow_clk),
    .uc_bit(uc_bit), .uc_clk(uc_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d, input logic sof);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = sof;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // serial expectation state
  logic [7:0]  ow_exp, uc_exp;
  logic [23:0] dcc_exp;
  logic [15:0] dhold;
  int ow_rem, uc_rem, dcc_rem, ow_cnt, uc_cnt, dcc_cnt;
  logic [6:0] ks;

  task automatic serial_step();
    if (ow_clk) ow_cnt++;
    if (uc_clk) uc_cnt++;
    if (dcc_clk) dcc_cnt++;
    if (ow_rem > 0) begin
      chk("R7", {ow_clk, ow_bit}, {1'b1, ow_exp[7]}); ow_exp = ow_exp << 1; ow_rem--;
    end else chk("R7", 32'(ow_clk), 32'd0);
    if (uc_rem > 0) begin
      chk("R8", {uc_clk, uc_bit}, {1'b1, uc_exp[7]}); uc_exp = uc_exp << 1; uc_rem--;
    end else chk("R8", 32'(uc_clk), 32'd0);
    if (dcc_rem > 0) begin
      chk("R9", {dcc_clk, dcc_bit}, {1'b1, dcc_exp[23]}); dcc_exp = dcc_exp << 1; dcc_rem--;
    end else chk("R9", 32'(dcc_clk), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    ow_rem = 0; uc_rem = 0; dcc_rem = 0;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11", 32'(out_valid), 32'd0);
    chk("R11", {ow_clk, uc_clk, dcc_clk}, 32'd0);
    chk("R1", 32'(in_ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;

    // R10: pre-sync bytes pass raw, no serial pulses
    descr_en = 1'b1;
    beat(8'h5A, 1'b0);
    chk("R10", {out_valid, out_data}, {1'b1, 8'h5A});
    chk("R2", 32'(out_sof), 32'd0);
    chk("R10", {ow_clk, uc_clk, dcc_clk}, 32'd0);

    // R1: back-pressure holds the byte, blocks input
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h33;
    #1 chk("R1", 32'(in_ready), 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R1", {out_valid, out_data}, {1'b1, 8'h5A});
    end
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1; in_valid = 1'b0;
    chk("R1", {out_valid, out_data}, {1'b1, 8'h33});
    @(posedge clk); #1;
    chk("R1", 32'(out_valid), 32'd0);

    // R10/R5: pre-sync AIS covers every byte
    ais_force = 1'b1;
    beat(8'h12, 1'b0);
    chk("R10", 32'(out_data), 32'hFF);
    ais_force = 1'b0;

    // R3..R9: frame scenarios from the table
    for (int s = 0; s < NSCN; s++) begin
      int n, rlen, total;
      logic xais;
      {sts3_mode, descr_en, ais_force, ais_auto_en, lof, los, xais} = SCN[s];
      n = sts3_mode ? 3 : 1;
      rlen = 90 * n;
      total = 13 * rlen;
      ow_cnt = 0; uc_cnt = 0; dcc_cnt = 0;
      ks = 7'h7F;
      for (int idx = 0; idx < total; idx++) begin
        int row, col;
        logic [7:0] raw, key, exp_d, exp_o;
        logic fixed, soh, sof;
        row = (idx / rlen) % 9;
        col = idx % rlen;
        sof = (idx % (9 * rlen)) == 0;
        raw = 8'((idx * 37) + (s * 11) + 5);
        fixed = (row == 0) && (col < 3 * n);
        soh = (row < 3) && (col < 3 * n);
        key = '0;
        if (fixed) ks = 7'h7F;
        else
          for (int b = 0; b < 8; b++) begin
            key[7-b] = ks[6];
            ks = {ks[5:0], ks[6] ^ ks[5]};
          end
        exp_d = (descr_en && !fixed) ? raw ^ key : raw;
        exp_o = (xais && !soh) ? 8'hFF : exp_d;
        beat(raw, sof);
        chk(xais ? "R5/R6" : "R4", {out_valid, out_data}, {1'b1, exp_o});
        chk("R3", 32'(out_sof), 32'(sof));
        serial_step();
        if (row == 1 && col == n)     begin ow_exp = exp_d; ow_rem = 8; end
        if (row == 1 && col == 2 * n) begin uc_exp = exp_d; uc_rem = 8; end
        if (row == 2 && col == 0)     dhold[15:8] = exp_d;
        if (row == 2 && col == n)     dhold[7:0] = exp_d;
        if (row == 2 && col == 2 * n) begin dcc_exp = {dhold, exp_d}; dcc_rem = 24; end
      end
      chk("R7", 32'(ow_cnt), 32'd16);
      chk("R8", 32'(uc_cnt), 32'd16);
      chk("R9", 32'(dcc_cnt), 32'd48);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule